// File: doc/BRIEF.md
# I2C Event Status Register

This block keeps the first status register of an I2C controller. The protocol engine reports what happened on the bus through one-cycle pulses: a bus start or stop, a finished byte in either direction, a slave address hit, a start generated as master, a missing acknowledge, lost arbitration, a bus fault and the sending of a 10-bit address header. The block stores one sticky condition bit for each of these events. From those bits it forms an 8-bit read-only status word: a summary event flag, the 10-bit header flag, a transfer direction flag and a bus busy flag.

Software clears the flags through its normal register accesses, which the host bus logic passes in as strobes: a read of this register, a read of the companion second status register, and a write to the data register. Error conditions clear in one step. Transfer-progress conditions and the header flag clear in two steps. The peripheral enable level clears all interface-owned state at once. The block has no data stream, so every pin is a plain level or pulse with no handshake.

Top module: `i2c_evt_status`

## Requirements
- R1: After reset the status word `stat_q` reads 00h and nothing is armed.
- R2: Bit 7 is the event flag, bit 6 the 10-bit header flag, bit 5 the direction flag and bit 4 the busy flag. Bits 3..0 always read 0, and `stat_rd` alone never changes the word.
- R3: Bit 7 is 1 exactly when at least one of eight stored conditions is set. The conditions are byte finished (`byte_tx_done` or `byte_rx_done`), address hit (`addr_hit` while `ack_enable` is 1), start sent (`start_sent`), no acknowledge (`nack_seen`), stop in slave mode (`evt_stop` while `slave_mode` is 1), arbitration lost (`arb_lost`), bus fault (`bus_fault`) and header sent (`hdr10_sent`).
- R4: The error conditions (no acknowledge, slave stop, arbitration lost, bus fault) clear on `aux_stat_rd`.
- R5: Byte finished, address hit and start sent clear only when `stat_rd` is followed later by `data_wr`. A `data_wr` that is not armed has no effect on them.
- R6: Bit 6 sets on `hdr10_sent` and clears only when `aux_stat_rd` is followed later by `data_wr`. A `data_wr` that is not armed leaves it set.
- R7: While `periph_en` is 0, bits 7..5, all conditions and both arming bits are cleared. Bit 4 is not affected.
- R8: Bit 5 becomes 1 after `byte_tx_done` and 0 after `byte_rx_done`. It clears when the byte-finished condition clears, on `evt_stop` and on `arb_lost`.
- R9: Bit 4 sets on `evt_start` and clears on `evt_stop` or `bus_fault`. When `evt_start` and `bus_fault` arrive together, the start wins. When `evt_start` and `evt_stop` arrive together, the stop wins.
- R10: If a condition's set and clear land in the same cycle, the condition ends up cleared.
- R11: An arming is used up by the `data_wr` that fires it. If the arming read and `data_wr` arrive in the same cycle, the result is armed and nothing is cleared.
- R12: Every result appears in `stat_q` right after the first rising edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Peripheral enable level |
| evt_start | input | 1 | Start condition seen on the bus |
| evt_stop | input | 1 | Stop condition seen on the bus |
| slave_mode | input | 1 | Level, 1 while the interface acts as slave |
| byte_tx_done | input | 1 | Byte transmitted and acknowledged |
| byte_rx_done | input | 1 | Byte received |
| addr_hit | input | 1 | Own slave address matched |
| ack_enable | input | 1 | Level, acknowledge generation enabled |
| start_sent | input | 1 | Start generated as master |
| nack_seen | input | 1 | No acknowledge after a transmitted byte |
| arb_lost | input | 1 | Arbitration lost as master |
| bus_fault | input | 1 | Misplaced start or stop |
| hdr10_sent | input | 1 | 10-bit address header sent as master |
| stat_rd | input | 1 | Read strobe of this register |
| aux_stat_rd | input | 1 | Read strobe of the second status register |
| data_wr | input | 1 | Write strobe of the data register |
| stat_q | output | 8 | Status word |

## Verification
Every flag is a register fed directly from its pulse. A change is therefore due in the cycle after the rising edge that samples the stimulus. Two-step clears take effect after the edge that samples `data_wr`, which must come at least one edge after the arming read. The bench drives all inputs on the falling edge, holds them for exactly one rising edge, and reads `stat_q` on the next falling edge. Each stimulus is then checked after exactly one register stage, with no race against the update.

// File: rtl/i2c_sts_pkg.sv
package i2c_sts_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned EVF_BIT = 7;
  localparam int unsigned HDR_BIT = 6;
  localparam int unsigned DIR_BIT = 5;
  localparam int unsigned BSY_BIT = 4;
  localparam int unsigned LOW_W   = BSY_BIT;

  localparam int unsigned N_COND = 8;
  localparam int unsigned C_BYTE = 0;
  localparam int unsigned C_ADDR = 1;
  localparam int unsigned C_SBIT = 2;
  localparam int unsigned C_NACK = 3;
  localparam int unsigned C_STOP = 4;
  localparam int unsigned C_ARB  = 5;
  localparam int unsigned C_BERR = 6;
  localparam int unsigned C_HDR  = 7;

  localparam int unsigned N_SEQ   = 2;
  localparam int unsigned SEQ_XFR = 0;
  localparam int unsigned SEQ_HDR = 1;

  typedef logic [N_COND-1:0] cond_t;
  typedef logic [N_SEQ-1:0]  seq_t;
endpackage

// File: rtl/i2c_sts_arm.sv
module i2c_sts_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic arm_i,
  input  logic fire_i,
  output logic armed_o,
  output logic clr_o
);
  logic armed_q;

  // The arming read takes priority; fire consumes an existing arming.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= en & (arm_i | (armed_q & ~fire_i));
  end

  assign armed_o = armed_q;
  assign clr_o   = armed_q & fire_i;
endmodule

// File: rtl/i2c_sts_cond.sv
module i2c_sts_cond
  import i2c_sts_pkg::*;
#(
  parameter int unsigned N = N_COND
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // Clear beats set; disable beats both.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= en & ~clr_i[g] & (set_i[g] | q[g]);
    end
  end

  assign q_o = q;
endmodule

// File: rtl/i2c_sts_line.sv
module i2c_sts_line (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_i,
  input  logic stop_i,
  input  logic fault_i,
  input  logic tx_i,
  input  logic rx_i,
  input  logic byte_clr_i,
  input  logic arb_i,
  output logic busy_o,
  output logic dir_o
);
  logic busy_q, dir_q, busy_n, dir_n;

  always_comb begin
    if (stop_i)       busy_n = 1'b0;
    else if (start_i) busy_n = 1'b1;
    else if (fault_i) busy_n = 1'b0;
    else              busy_n = busy_q;
  end

  always_comb begin
    if (!en || byte_clr_i || stop_i || arb_i) dir_n = 1'b0;
    else if (tx_i)                            dir_n = 1'b1;
    else if (rx_i)                            dir_n = 1'b0;
    else                                      dir_n = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      dir_q  <= dir_n;
    end
  end

  assign busy_o = busy_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_sts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_en,
  input  logic             evt_start,
  input  logic             evt_stop,
  input  logic             slave_mode,
  input  logic             byte_tx_done,
  input  logic             byte_rx_done,
  input  logic             addr_hit,
  input  logic             ack_enable,
  input  logic             start_sent,
  input  logic             nack_seen,
  input  logic             arb_lost,
  input  logic             bus_fault,
  input  logic             hdr10_sent,
  input  logic             stat_rd,
  input  logic             aux_stat_rd,
  input  logic             data_wr,
  output logic [REG_W-1:0] stat_q
);
  cond_t set_v, clr_v, cond;
  seq_t  arm_v, seq_armed, seq_clr;
  logic  busy, dir;

  always_comb begin
    set_v         = '0;
    set_v[C_BYTE] = byte_tx_done | byte_rx_done;
    set_v[C_ADDR] = addr_hit & ack_enable;
    set_v[C_SBIT] = start_sent;
    set_v[C_NACK] = nack_seen;
    set_v[C_STOP] = evt_stop & slave_mode;
    set_v[C_ARB]  = arb_lost;
    set_v[C_BERR] = bus_fault;
    set_v[C_HDR]  = hdr10_sent;
  end

  assign arm_v[SEQ_XFR] = stat_rd;
  assign arm_v[SEQ_HDR] = aux_stat_rd;

  for (genvar s = 0; s < N_SEQ; s++) begin : g_seq
    i2c_sts_arm u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (periph_en),
      .arm_i  (arm_v[s]),
      .fire_i (data_wr),
      .armed_o(seq_armed[s]),
      .clr_o  (seq_clr[s])
    );
  end

  always_comb begin
    clr_v         = '0;
    clr_v[C_BYTE] = seq_clr[SEQ_XFR];
    clr_v[C_ADDR] = seq_clr[SEQ_XFR];
    clr_v[C_SBIT] = seq_clr[SEQ_XFR];
    clr_v[C_NACK] = aux_stat_rd;
    clr_v[C_STOP] = aux_stat_rd;
    clr_v[C_ARB]  = aux_stat_rd;
    clr_v[C_BERR] = aux_stat_rd;
    clr_v[C_HDR]  = seq_clr[SEQ_HDR];
  end

  i2c_sts_cond #(.N(N_COND)) u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (periph_en),
    .set_i(set_v),
    .clr_i(clr_v),
    .q_o  (cond)
  );

  i2c_sts_line u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (periph_en),
    .start_i   (evt_start),
    .stop_i    (evt_stop),
    .fault_i   (bus_fault),
    .tx_i      (byte_tx_done),
    .rx_i      (byte_rx_done),
    .byte_clr_i(clr_v[C_BYTE]),
    .arb_i     (arb_lost),
    .busy_o    (busy),
    .dir_o     (dir)
  );

  always_comb begin
    stat_q          = '0;
    stat_q[EVF_BIT] = |cond;
    stat_q[HDR_BIT] = cond[C_HDR];
    stat_q[DIR_BIT] = dir;
    stat_q[BSY_BIT] = busy;
  end
endmodule

// File: rtl/i2c_evt_status_chk.sv
module i2c_evt_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       periph_en,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       slave_mode,
  input logic       byte_tx_done,
  input logic       byte_rx_done,
  input logic       addr_hit,
  input logic       ack_enable,
  input logic       start_sent,
  input logic       nack_seen,
  input logic       arb_lost,
  input logic       bus_fault,
  input logic       hdr10_sent,
  input logic       stat_rd,
  input logic       aux_stat_rd,
  input logic       data_wr,
  input logic [7:0] stat_q
);
  logic any_set;
  assign any_set = byte_tx_done | byte_rx_done | (addr_hit & ack_enable) |
                   start_sent | nack_seen | (evt_stop & slave_mode) |
                   arb_lost | bus_fault | hdr10_sent;

  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[3:0] == 4'b0);

  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> stat_q[7:5] == 3'b0);

  p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start && !evt_stop |=> stat_q[4]);

  p_busy_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !stat_q[4]);

  p_dir_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[5]) |-> $past(byte_tx_done));

  p_hdr_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[6]) |-> ($past(data_wr) || !$past(periph_en)));

  p_evf_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[7]) |-> $past(any_set));
endmodule

bind i2c_evt_status i2c_evt_status_chk u_chk (.*);

// File: tb/sim_i2c_evt_status.sv
module sim_i2c_evt_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en = 1'b0;
  logic evt_start = 0, evt_stop = 0, slave_mode = 0, byte_tx_done = 0;
  logic byte_rx_done = 0, addr_hit = 0, ack_enable = 0, start_sent = 0;
  logic nack_seen = 0, arb_lost = 0, bus_fault = 0, hdr10_sent = 0;
  logic stat_rd = 0, aux_stat_rd = 0, data_wr = 0;
  logic [7:0] stat_q;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  i2c_evt_status u0 (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    evt_start = 0; evt_stop = 0; byte_tx_done = 0; byte_rx_done = 0;
    addr_hit = 0; start_sent = 0; nack_seen = 0; arb_lost = 0;
    bus_fault = 0; hdr10_sent = 0; stat_rd = 0; aux_stat_rd = 0; data_wr = 0;
  endtask

  task automatic chk(input logic [7:0] exp, input string req);
    total++;
    if (stat_q !== exp) begin
      bad++;
      $display("FAIL %s: stat_q=%02h expected=%02h", req, stat_q, exp);
    end
  endtask

  task automatic fire_src(input int i);
    case (i)
      0: byte_tx_done = 1;
      1: addr_hit = 1;
      2: start_sent = 1;
      3: nack_seen = 1;
      4: evt_stop = 1;
      5: arb_lost = 1;
      6: bus_fault = 1;
      default: hdr10_sent = 1;
    endcase
  endtask

  initial begin
    #(20 * 5000);
    bad++;
    $display("FAIL watchdog: stat_q=%02h expected=done", stat_q);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(8'h00, "R1 reset");
    rst_n = 1; periph_en = 1; ack_enable = 1; slave_mode = 1;
    step();
    chk(8'h00, "R1 after release");

    // R3 R4 R5 R6 sweep over all eight event sources
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      data_wr = 1; step();               // flush any arming
      fire_src(i); step();
      e = 8'h80 | ((i == 7) ? 8'h40 : 8'h00) | ((i == 0) ? 8'h20 : 8'h00);
      chk(e, "R3 source set");
      data_wr = 1; step();
      chk(e, "R5/R6 unarmed write ignored");
      stat_rd = 1; step();
      chk(e, "R2 own read no change");
      if (i >= 3 && i <= 6) begin
        aux_stat_rd = 1; step();
        chk(8'h00, "R4 error cleared by aux read");
      end else if (i == 7) begin
        aux_stat_rd = 1; step();
        chk(e, "R6 aux read alone keeps header");
        data_wr = 1; step();
        chk(8'h00, "R6 two-step clear");
      end else begin
        data_wr = 1; step();              // arming from stat_rd above
        chk(8'h00, "R5 two-step clear");
      end
    end

    // R3 gating by levels
    data_wr = 1; step();
    ack_enable = 0; addr_hit = 1; step();
    chk(8'h00, "R3 addr hit without ack enable");
    slave_mode = 0; evt_stop = 1; step();
    chk(8'h00, "R3 stop in master mode");
    ack_enable = 1; slave_mode = 1;

    // R8 direction
    byte_rx_done = 1; step();
    chk(8'h80, "R8 rx byte dir 0");
    byte_tx_done = 1; step();
    chk(8'hA0, "R8 tx byte dir 1");
    arb_lost = 1; step();
    chk(8'h80, "R8 arb lost clears dir");
    aux_stat_rd = 1; step();
    byte_tx_done = 1; step();
    chk(8'hA0, "R8 tx again");
    evt_stop = 1; slave_mode = 0; step();
    chk(8'h80, "R8 stop clears dir");
    slave_mode = 1;
    stat_rd = 1; step();
    data_wr = 1; step();
    chk(8'h00, "R8 byte clear leaves dir 0");

    // R9 busy
    evt_start = 1; step();
    chk(8'h10, "R9 start sets busy");
    evt_stop = 1; slave_mode = 0; step();
    chk(8'h00, "R9 stop clears busy");
    evt_start = 1; step();
    bus_fault = 1; step();
    chk(8'h80, "R9 fault clears busy");
    aux_stat_rd = 1; step();
    evt_start = 1; bus_fault = 1; step();
    chk(8'h90, "R9 start beats fault");
    aux_stat_rd = 1; evt_start = 1; evt_stop = 1; step();
    chk(8'h00, "R9 stop beats start");

    // R10 same-cycle set and clear
    stat_rd = 1; step();
    data_wr = 1; byte_tx_done = 1; step();
    chk(8'h00, "R10 armed clear beats byte set");
    aux_stat_rd = 1; nack_seen = 1; step();
    chk(8'h00, "R10 aux read beats nack set");

    // R11 same-cycle arm and fire, then consume
    hdr10_sent = 1; data_wr = 1; step();       // consume leftover arming
    chk(8'h00, "R10 header set with clear");
    hdr10_sent = 1; step();
    aux_stat_rd = 1; data_wr = 1; step();
    chk(8'hC0, "R11 arm and write same cycle");
    data_wr = 1; step();
    chk(8'h00, "R11 arming fires next write");
    hdr10_sent = 1; step();
    data_wr = 1; step();
    chk(8'hC0, "R11 arming used up");

    // R7 disable, and arming cancel
    evt_start = 1; byte_tx_done = 1; step();
    chk(8'hF0, "R12 all upper flags");
    aux_stat_rd = 1; step();
    periph_en = 0; step();
    chk(8'h10, "R7 disable clears flags keeps busy");
    periph_en = 1; hdr10_sent = 1; step();
    data_wr = 1; step();
    chk(8'hD0, "R7 arming cancelled by disable");
    evt_stop = 1; aux_stat_rd = 1; step();
    data_wr = 1; step();
    chk(8'h00, "R6 final clear");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule